// File: doc/BRIEF.md
# Prefixed Instruction Word Combiner

This block sits between instruction fetch and the decode table. It receives a stream of fetched words. Each word arrives with a predecoded operation code, the raw 32-bit word and its fetch address. The block folds a two-word prefixed instruction into a single operation for decode. A word whose primary opcode (bits 31:26) equals 1 is a prefix. The block holds it and emits nothing in that cycle. The next valid word is taken as its suffix, and one merged operation leaves the block.

The merged operation carries the following:
- The suffix code with its least significant bit set, so the decode table picks the prefixed variant.
- The prefix word.
- A flag for an illegal prefix/suffix form. The flag does not change the code.
- A sign-extended 34-bit immediate.
- The PC-relative select bit.
- The address of the prefix. This is rebuilt by placing the saved prefix address bits 5:2 over the suffix address.

A prefix that sits in the last word of a 64-byte block would cross that boundary. Such a prefix is reported at once as an alignment fault. A flush discards any held prefix. Every output is registered, so an accepted word shows at the outputs one clock later.

Top module: `pfx_combine`

## Requirements
- R1: A valid word with bits 31:26 equal to 1, arriving with no prefix held and not at address 60 mod 64, is held, and `out_valid` is 0 in the following cycle.
- R2: The next valid word after a held prefix is its suffix, whatever idle cycles come between. One cycle after it is accepted, `out_valid`=1, `out_prefixed`=1, and `out_prefix` equals the held prefix word.
- R3: A merged operation reports the suffix code with bit 0 set. A plain operation reports its input code unchanged.
- R4: A prefix with subtype bit 23 set marks the merged operation illegal (`out_illegal`=1).
- R5: The prefix type in bits 25:24 limits which suffix opcodes (bits 31:26) are legal. Type 0 accepts 57 and 61. Type 2 accepts 14, 32, 34, 36, 38, 40, 42, 44, 48, 50, 52 and 54. Types 1 and 3 accept none. Any other suffix sets `out_illegal`, and the code is still only bit-0 set.
- R6: The address of a merged operation is the suffix address with bits 5:2 replaced by those of the prefix address.
- R7: A prefix at an address of 60 mod 64, arriving with no prefix held, is emitted at once with `out_align_fault`=1, `out_prefixed`=0 and its own address and code. It is not held, so the next word is a plain operation.
- R8: A merged immediate is {prefix bits 17:0, suffix bits 15:0}, sign-extended from bit 33 to `IMM_W`. `out_pcrel` equals prefix bit 20.
- R9: A plain operation reports the sign-extended low 16 bits of its word as the immediate. Its `out_prefix`, `out_illegal`, `out_pcrel` and `out_align_fault` are all 0.
- R10: With `flush` high, the held prefix is dropped, the input word is ignored, and `out_valid` is 0 in the following cycle.
- R11: During reset and in the first cycle after it, `out_valid` is 0 and no prefix is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard the held prefix and the current word |
| in_valid | input | 1 | Input word present |
| in_code | input | CODE_W | Predecoded operation code |
| in_word | input | 32 | Raw instruction word |
| in_addr | input | ADDR_W | Fetch address of the word |
| out_valid | output | 1 | Operation present |
| out_code | output | CODE_W | Code for the decode table |
| out_prefix | output | 32 | Prefix word, 0 for plain operations |
| out_prefixed | output | 1 | Operation was merged from two words |
| out_illegal | output | 1 | Invalid prefix/suffix form |
| out_align_fault | output | 1 | Prefix would cross a 64-byte boundary |
| out_pcrel | output | 1 | PC-relative addressing selected |
| out_imm | output | IMM_W | Sign-extended immediate |
| out_addr | output | ADDR_W | Operation address |

## Verification
The main function is tried with several patterns:
- A plain word next to merged pairs of both legal prefix types. This separates code remapping from pass-through.
- A prefix with positive and with negative displacement. This checks the sign extension of bit 33.
- A reserved subtype, and a suffix that the prefix type rejects. These confirm that illegality raises only the flag and leaves the code alone.
- A prefix followed by idle cycles before its suffix. This shows that pairing is by valid word, not by cycle.
- A prefix in the last word of a 64-byte block, and a flush between prefix and suffix. Each of these must leave the following word decoded as a plain operation.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned IMM_BITS = 34;
   localparam logic [5:0]  PFX_OPC  = 6'd1;

   typedef enum logic [1:0] {
      PT_LS8  = 2'd0,
      PT_MMR  = 2'd1,
      PT_MLS  = 2'd2,
      PT_RSV  = 2'd3
   } pfx_type_e;

   function automatic logic [5:0] opc_of(input logic [WORD_W-1:0] w);
      return w[31:26];
   endfunction

   function automatic pfx_type_e type_of(input logic [WORD_W-1:0] w);
      return pfx_type_e'(w[25:24]);
   endfunction
endpackage

// File: rtl/pfx_hold.sv
module pfx_hold
   import pfx_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              capture,
   input  logic              consume,
   input  logic [WORD_W-1:0] word_in,
   input  logic [3:0]        mid_in,
   output logic              held,
   output logic [WORD_W-1:0] held_word,
   output logic [3:0]        held_mid
);
   initial begin
      if (ADDR_W < 7) $error("pfx_hold: ADDR_W must reach bit 6");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held      <= 1'b0;
         held_word <= '0;
         held_mid  <= '0;
      end else if (flush) begin
         held <= 1'b0;
      end else if (capture) begin
         held      <= 1'b1;
         held_word <= word_in;
         held_mid  <= mid_in;
      end else if (consume) begin
         held <= 1'b0;
      end
   end

   AST_NO_DOUBLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      held && !flush |-> !capture) else $error("capture while held"); // R2

   AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !held) else $error("flush left prefix held"); // R10
endmodule

// File: rtl/pfx_form_check.sv
module pfx_form_check
   import pfx_pkg::*;
#(
   parameter logic [63:0] LS8_OK = 64'h2200_0000_0000_0000,
   parameter logic [63:0] MLS_OK = 64'h0055_1555_0000_4000,
   parameter logic [63:0] MMR_OK = 64'h0,
   parameter logic [63:0] RSV_OK = 64'h0
)(
   input  logic [WORD_W-1:0] pfx_word,
   input  logic [WORD_W-1:0] sfx_word,
   output logic              illegal
);
   logic [63:0] allowed [4];
   logic        sub_rsv;
   logic        sfx_ok;

   assign allowed[0] = LS8_OK;
   assign allowed[1] = MMR_OK;
   assign allowed[2] = MLS_OK;
   assign allowed[3] = RSV_OK;

   assign sub_rsv = pfx_word[23];

   always_comb begin
      sfx_ok = 1'b0;
      for (int t = 0; t < 4; t++) begin
         if (type_of(pfx_word) == pfx_type_e'(t))
            sfx_ok = allowed[t][opc_of(sfx_word)];
      end
   end

   assign illegal = sub_rsv | ~sfx_ok;
endmodule

// File: rtl/pfx_imm_build.sv
module pfx_imm_build
   import pfx_pkg::*;
#(
   parameter int unsigned IMM_W = 64
)(
   input  logic              merge,
   input  logic [WORD_W-1:0] pfx_word,
   input  logic [WORD_W-1:0] sfx_word,
   output logic [IMM_W-1:0]  imm,
   output logic              pcrel
);
   localparam int unsigned EXT_W = IMM_W - IMM_BITS;

   logic [IMM_BITS-1:0] raw;

   initial begin
      if (IMM_W < IMM_BITS) $error("pfx_imm_build: IMM_W below 34");
   end

   assign raw   = merge ? {pfx_word[17:0], sfx_word[15:0]}
                        : {{(IMM_BITS-16){sfx_word[15]}}, sfx_word[15:0]};
   assign pcrel = merge & pfx_word[20];

   generate
      if (EXT_W == 0) begin : g_exact
         assign imm = raw;
      end else begin : g_ext
         assign imm = {{EXT_W{raw[IMM_BITS-1]}}, raw};
      end
   endgenerate
endmodule

// File: rtl/pfx_combine.sv
module pfx_combine
   import pfx_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CODE_W = 8,
   parameter int unsigned IMM_W  = 64,
   parameter logic [63:0] LS8_OK = 64'h2200_0000_0000_0000,
   parameter logic [63:0] MLS_OK = 64'h0055_1555_0000_4000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              in_valid,
   input  logic [CODE_W-1:0] in_code,
   input  logic [31:0]       in_word,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              out_valid,
   output logic [CODE_W-1:0] out_code,
   output logic [31:0]       out_prefix,
   output logic              out_prefixed,
   output logic              out_illegal,
   output logic              out_align_fault,
   output logic              out_pcrel,
   output logic [IMM_W-1:0]  out_imm,
   output logic [ADDR_W-1:0] out_addr
);
   localparam logic [CODE_W-1:0] CODE_LSB = CODE_W'(1);
   localparam logic [3:0]        LAST_MID = 4'hF;

   initial begin
      if (CODE_W < 2)  $error("pfx_combine: CODE_W too small");
      if (ADDR_W < 7)  $error("pfx_combine: ADDR_W too small");
      if (IMM_W < 34)  $error("pfx_combine: IMM_W too small");
   end

   logic              held;
   logic [31:0]       held_word;
   logic [3:0]        held_mid;
   logic              accept, is_pfx, at_edge;
   logic              capture, merge, emit, fault;
   logic              form_bad;
   logic [IMM_W-1:0]  imm_nx;
   logic              pcrel_nx;
   logic [ADDR_W-1:0] addr_nx;

   assign accept  = in_valid & ~flush;
   assign is_pfx  = opc_of(in_word) == PFX_OPC;
   assign at_edge = in_addr[5:2] == LAST_MID;
   assign merge   = accept & held;
   assign fault   = accept & ~held & is_pfx & at_edge;
   assign capture = accept & ~held & is_pfx & ~at_edge;
   assign emit    = accept & ~capture;

   pfx_hold #(.ADDR_W(ADDR_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .capture   (capture),
      .consume   (merge),
      .word_in   (in_word),
      .mid_in    (in_addr[5:2]),
      .held      (held),
      .held_word (held_word),
      .held_mid  (held_mid)
   );

   pfx_form_check #(.LS8_OK(LS8_OK), .MLS_OK(MLS_OK)) u_form (
      .pfx_word (held_word),
      .sfx_word (in_word),
      .illegal  (form_bad)
   );

   pfx_imm_build #(.IMM_W(IMM_W)) u_imm (
      .merge    (merge),
      .pfx_word (held_word),
      .sfx_word (in_word),
      .imm      (imm_nx),
      .pcrel    (pcrel_nx)
   );

   always_comb begin
      addr_nx = in_addr;
      if (merge) addr_nx[5:2] = held_mid;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid       <= 1'b0;
         out_code        <= '0;
         out_prefix      <= '0;
         out_prefixed    <= 1'b0;
         out_illegal     <= 1'b0;
         out_align_fault <= 1'b0;
         out_pcrel       <= 1'b0;
         out_imm         <= '0;
         out_addr        <= '0;
      end else begin
         out_valid <= emit;
         if (emit) begin
            out_code        <= merge ? (in_code | CODE_LSB) : in_code;
            out_prefix      <= merge ? held_word : 32'h0;
            out_prefixed    <= merge;
            out_illegal     <= merge & form_bad;
            out_align_fault <= fault;
            out_pcrel       <= pcrel_nx;
            out_imm         <= imm_nx;
            out_addr        <= addr_nx;
         end
      end
   end

   AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !flush && !held && is_pfx && !at_edge |=> !out_valid)
      else $error("prefix emitted"); // R1

   AST_CODE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_prefixed |-> out_code == ($past(in_code) | CODE_LSB))
      else $error("suffix code not remapped"); // R3

   AST_FAULT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      out_align_fault && out_valid |-> !out_prefixed && !out_illegal)
      else $error("fault on merged op"); // R7

   AST_IMM_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_imm[IMM_W-1:33] == '0) || (&out_imm[IMM_W-1:33]))
      else $error("immediate not sign-extended"); // R8

   AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !out_valid) else $error("output after flush"); // R10
endmodule

// File: tb/test_pfx_combine.sv
module test_pfx_combine;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_code = '0;
   logic [31:0] in_word = '0;
   logic [31:0] in_addr = '0;
   logic        out_valid, out_prefixed, out_illegal, out_align_fault, out_pcrel;
   logic [7:0]  out_code;
   logic [31:0] out_prefix, out_addr;
   logic [63:0] out_imm;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pfx_combine i_pfx_combine (
      .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
      .in_code(in_code), .in_word(in_word), .in_addr(in_addr),
      .out_valid(out_valid), .out_code(out_code), .out_prefix(out_prefix),
      .out_prefixed(out_prefixed), .out_illegal(out_illegal),
      .out_align_fault(out_align_fault), .out_pcrel(out_pcrel),
      .out_imm(out_imm), .out_addr(out_addr)
   );

   typedef struct packed {
      logic        v;
      logic [7:0]  code;
      logic [31:0] word;
      logic [31:0] addr;
      logic        ev;
      logic        ep;
      logic        eil;
      logic        eal;
      logic        epc;
      logic [7:0]  ecode;
      logic [31:0] eaddr;
      logic [63:0] eimm;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      // R9 R3 plain word, negative imm
      '{1'b1, 8'h10, 32'h3880_FFFC, 32'h100, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'h10, 32'h100, 64'hFFFF_FFFF_FFFF_FFFC},
      // R1 MLS prefix, R=1, d0=1
      '{1'b1, 8'h02, 32'h0610_0001, 32'h104, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 32'h0, 64'h0},
      // R2 R3 R6 R8 suffix addi
      '{1'b1, 8'h20, 32'h3860_0002, 32'h108, 1'b1,1'b1,1'b0,1'b0,1'b1, 8'h21, 32'h104, 64'h0000_0000_0001_0002},
      // R1 8LS prefix, d0 all ones
      '{1'b1, 8'h02, 32'h0403_FFFF, 32'h110, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 32'h0, 64'h0},
      // R5 R8 legal opcode 57 suffix, negative imm
      '{1'b1, 8'h30, 32'hE400_0010, 32'h114, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'h31, 32'h110, 64'hFFFF_FFFF_FFFF_0010},
      // R4 reserved subtype prefix
      '{1'b1, 8'h02, 32'h0680_0000, 32'h120, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 32'h0, 64'h0},
      '{1'b1, 8'h20, 32'h3800_0000, 32'h124, 1'b1,1'b1,1'b1,1'b0,1'b0, 8'h21, 32'h120, 64'h0},
      // R5 type 0 prefix with addi suffix rejected
      '{1'b1, 8'h02, 32'h0400_0000, 32'h130, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 32'h0, 64'h0},
      '{1'b1, 8'h20, 32'h3800_0005, 32'h134, 1'b1,1'b1,1'b1,1'b0,1'b0, 8'h21, 32'h130, 64'h5},
      // R7 prefix at 60 mod 64
      '{1'b1, 8'h02, 32'h0600_0000, 32'h13C, 1'b1,1'b0,1'b0,1'b1,1'b0, 8'h02, 32'h13C, 64'h0},
      '{1'b1, 8'h10, 32'h3800_0007, 32'h140, 1'b1,1'b0,1'b0,1'b0,1'b0, 8'h10, 32'h140, 64'h7},
      // R2 idle cycle gives nothing
      '{1'b0, 8'h00, 32'h0, 32'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 32'h0, 64'h0},
      // R5 type 1 prefix, idle gap, suffix rejected
      '{1'b1, 8'h02, 32'h0500_0000, 32'h150, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 32'h0, 64'h0},
      '{1'b0, 8'h00, 32'h0, 32'h0, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 32'h0, 64'h0},
      '{1'b1, 8'h40, 32'h8000_0000, 32'h154, 1'b1,1'b1,1'b1,1'b0,1'b0, 8'h41, 32'h150, 64'h0},
      // R5 MLS with opcode 32 legal
      '{1'b1, 8'h02, 32'h0600_0000, 32'h160, 1'b0,1'b0,1'b0,1'b0,1'b0, 8'h00, 32'h0, 64'h0},
      '{1'b1, 8'h40, 32'h8000_0008, 32'h164, 1'b1,1'b1,1'b0,1'b0,1'b0, 8'h41, 32'h160, 64'h8}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [7:0] c, input logic [31:0] w,
                       input logic [31:0] a, input logic fl);
      @(negedge clk);
      in_valid = v; in_code = c; in_word = w; in_addr = a; flush = fl;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R11 valid in reset", out_valid, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R11 valid after reset", out_valid, 0);

      // R11: a plain word right after reset must not merge with anything
      step(1'b1, 8'h10, 32'h3800_0003, 32'h104, 1'b0);
      chk("R11 no held prefix", out_prefixed, 0);
      chk("R11 address", out_addr, 32'h104);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i].v, VEC[i].code, VEC[i].word, VEC[i].addr, 1'b0);
         chk($sformatf("R1/R2 valid vec%0d", i), out_valid, VEC[i].ev);
         if (VEC[i].ev) begin
            chk($sformatf("R2 prefixed vec%0d", i), out_prefixed, VEC[i].ep);
            chk($sformatf("R3 code vec%0d", i), out_code, VEC[i].ecode);
            chk($sformatf("R4/R5 illegal vec%0d", i), out_illegal, VEC[i].eil);
            chk($sformatf("R7 fault vec%0d", i), out_align_fault, VEC[i].eal);
            chk($sformatf("R8 pcrel vec%0d", i), out_pcrel, VEC[i].epc);
            chk($sformatf("R6 addr vec%0d", i), out_addr, VEC[i].eaddr);
            chk($sformatf("R8/R9 imm vec%0d", i), out_imm, VEC[i].eimm);
            if (!VEC[i].ep)
               chk($sformatf("R9 prefix zero vec%0d", i), out_prefix, 0);
         end
      end

      // R2: prefix word is carried out with the merged op
      step(1'b1, 8'h02, 32'h0612_3456, 32'h204, 1'b0);
      step(1'b1, 8'h20, 32'h3800_0001, 32'h208, 1'b0);
      chk("R2 prefix word", out_prefix, 32'h0612_3456);

      // R10: flush drops held prefix and ignores the word
      step(1'b1, 8'h02, 32'h0600_0000, 32'h304, 1'b0);
      step(1'b1, 8'h20, 32'h3800_0009, 32'h308, 1'b1);
      chk("R10 no op on flush", out_valid, 0);
      step(1'b1, 8'h20, 32'h3800_000A, 32'h30C, 1'b0);
      chk("R10 valid after flush", out_valid, 1);
      chk("R10 word not merged", out_prefixed, 0);
      chk("R10 code unchanged", out_code, 8'h20);
      chk("R10 address own", out_addr, 32'h30C);

      step(1'b0, 8'h00, 32'h0, 32'h0, 1'b0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule